// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor

This block adds or subtracts two multi-word field elements modulo a fixed odd modulus. The operands are N words of W bits each. They come in one word pair at a time, least-significant word first, and the block keeps only a single carry/borrow bit between words. The result words are held in a small word store. Depending on the operation and the outcome, the block then runs one or two extra word-serial passes over that store: a most-significant-first magnitude compare against the modulus, and a correction pass that subtracts the modulus (after an addition) or adds it (after a subtraction that borrowed). Finally it streams the result out, least-significant word first.

A caller pulses `start_i` while the block is idle and selects addition or subtraction and full or partial reduction. It then presents N word pairs, qualified by `in_valid_i`; gaps are allowed. The result appears as N consecutive `out_valid_o` cycles, and `done_o` marks the last word. Partial reduction lets values lie anywhere in the full N·W-bit range. This removes the compare pass, so an addition is corrected only when its final carry is set.

Top module: `modadd_ws`

## Requirements
- R1: After reset, `busy_o`, `out_valid_o` and `done_o` are all low.
- R2: In full-reduction addition with both operands in [0, p−1], the streamed result equals (a + b) mod p, with word k on bits [k·W+W−1 : k·W] and word 0 sent first.
- R3: In full-reduction addition, the modulus is subtracted when the final carry is 1 or when the N·W-bit sum is at least p; a sum exactly equal to p yields zero.
- R4: In partial-reduction addition, no compare pass runs. The result is (a + b) mod 2^(N·W) when the final carry is 0, and (a + b − p) mod 2^(N·W) when it is 1.
- R5: Subtraction (`sub_i`=1) yields a − b when a ≥ b and (a − b + p) mod 2^(N·W) when a < b, whatever the reduction mode.
- R6: Counted from the first cycle after the last word pair is accepted, the first output word appears after 0 idle cycles when neither compare nor correction runs, after N cycles when only one of them runs, and after 2N cycles when both run. The compare runs only in full-reduction addition with final carry 0.
- R7: The result leaves as exactly N back-to-back `out_valid_o` cycles, and `done_o` is high only together with the last word.
- R8: A word pair is consumed only in a cycle where `in_valid_i` is high during loading. Data presented with `in_valid_i` low has no effect on the result.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The operation in progress completes with its own result and timing.
- R10: `busy_o` rises in the cycle after an accepted start, stays high through the last output word, and falls in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only while idle) |
| sub_i | input | 1 | 1 = subtraction, 0 = addition; sampled with start |
| partial_i | input | 1 | 1 = partial reduction (no compare pass); sampled with start |
| in_valid_i | input | 1 | Qualifies the current operand word pair |
| a_word_i | input | W | Word of operand a, least-significant first |
| b_word_i | input | W | Word of operand b, least-significant first |
| busy_o | output | 1 | Operation in progress |
| out_valid_o | output | 1 | Result word valid |
| out_word_o | output | W | Result word, least-significant first |
| done_o | output | 1 | High with the last result word |

## Verification
The assertions assume that `start_i` is a short pulse and that the caller supplies exactly N valid word pairs after each accepted start. They also assume that full-reduction operands lie in [0, p−1], since the single correction pass can only remove one multiple of p. The stimulus reduces every full-mode random operand below p before use. It uses values above p only in partial-reduction runs, where the extended range is legal. The stimulus stops driving `in_valid_i` once the last pair is in. Start pulses during busy periods are placed only inside load gaps, so the one-cycle start shape that the assertions rely on is preserved.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

    localparam int unsigned DEF_WORD_W    = 16;
    localparam int unsigned DEF_NUM_WORDS = 12;

    // 2^192 - 2^64 - 1
    localparam logic [191:0] DEF_MODULUS =
        192'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFFFF_FFFFFFFF;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_CMP  = 3'd2,
        ST_FIX  = 3'd3,
        ST_EMIT = 3'd4
    } mas_state_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mas_op_e;

    typedef struct packed {
        mas_op_e op;
        logic    partial;
    } mas_cfg_t;

endpackage

// File: rtl/modadd_word_alu.sv
module modadd_word_alu #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] z_o,
    output logic         cout_o
);
    logic [W:0] ext;

    always_comb begin
        if (sub_i) begin
            ext = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, cin_i};
        end else begin
            ext = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        end
        z_o    = ext[W-1:0];
        cout_o = ext[W];
    end
endmodule

// File: rtl/modadd_word_store.sv
module modadd_word_store #(
    parameter int unsigned W     = 16,
    parameter int unsigned N     = 12,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [W-1:0]     rdata_o
);
    logic [W-1:0] rf [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we_i && (widx_i == IDX_W'(g))) begin
                rf[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < N; k++) begin
            if (ridx_i == IDX_W'(k)) begin
                rdata_o = rf[k];
            end
        end
    end
endmodule

// File: rtl/modadd_mag_cmp.sv
module modadd_mag_cmp #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] r_word_i,
    input  logic [W-1:0] p_word_i,
    output logic         ge_now_o
);
    logic decided_q;
    logic ge_q;

    // Verdict including the word currently presented; a full tie means r == p.
    assign ge_now_o = decided_q ? ge_q : (r_word_i >= p_word_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            decided_q <= 1'b0;
            ge_q      <= 1'b0;
        end else if (step_i && !decided_q && (r_word_i != p_word_i)) begin
            decided_q <= 1'b1;
            ge_q      <= (r_word_i > p_word_i);
        end
    end
endmodule

// File: rtl/modadd_ws.sv
module modadd_ws
    import modadd_pkg::*;
#(
    parameter int unsigned   W       = DEF_WORD_W,
    parameter int unsigned   N       = DEF_NUM_WORDS,
    parameter logic [N*W-1:0] MODULUS = DEF_MODULUS[N*W-1:0]
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         sub_i,
    input  logic         partial_i,
    input  logic         in_valid_i,
    input  logic [W-1:0] a_word_i,
    input  logic [W-1:0] b_word_i,
    output logic         busy_o,
    output logic         out_valid_o,
    output logic [W-1:0] out_word_o,
    output logic         done_o
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    mas_state_e       state_q;
    mas_cfg_t         cfg_q;
    logic [IDX_W-1:0] idx_q;
    logic             cb_q;

    logic [W-1:0]     p_word;
    logic [W-1:0]     st_rdata;
    logic             st_we;
    logic [W-1:0]     alu_x, alu_y, alu_z;
    logic             alu_sub, alu_cout;
    logic             cmp_ge;
    logic             at_last;

    assign at_last = (idx_q == LAST_IDX);
    assign p_word  = MODULUS[idx_q*W +: W];

    // Operand routing: pass one takes the inputs, the correction pass
    // works on the stored word against the modulus word.
    always_comb begin
        if (state_q == ST_FIX) begin
            alu_x   = st_rdata;
            alu_y   = p_word;
            alu_sub = (cfg_q.op == OP_ADD);
        end else begin
            alu_x   = a_word_i;
            alu_y   = b_word_i;
            alu_sub = (cfg_q.op == OP_SUB);
        end
    end

    assign st_we = ((state_q == ST_LOAD) && in_valid_i) || (state_q == ST_FIX);

    modadd_word_alu #(.W(W)) alu_i (
        .x_i    (alu_x),
        .y_i    (alu_y),
        .cin_i  (cb_q),
        .sub_i  (alu_sub),
        .z_o    (alu_z),
        .cout_o (alu_cout)
    );

    modadd_word_store #(.W(W), .N(N), .IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .we_i    (st_we),
        .widx_i  (idx_q),
        .wdata_i (alu_z),
        .ridx_i  (idx_q),
        .rdata_o (st_rdata)
    );

    modadd_mag_cmp #(.W(W)) cmp_i (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (state_q != ST_CMP),
        .step_i   (state_q == ST_CMP),
        .r_word_i (st_rdata),
        .p_word_i (p_word),
        .ge_now_o (cmp_ge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '{op: OP_ADD, partial: 1'b0};
            idx_q   <= '0;
            cb_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LOAD;
                        cfg_q   <= '{op: mas_op_e'(sub_i), partial: partial_i};
                        idx_q   <= '0;
                        cb_q    <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (in_valid_i) begin
                        if (at_last) begin
                            cb_q <= 1'b0;
                            if (alu_cout) begin
                                state_q <= ST_FIX;
                                idx_q   <= '0;
                            end else if (cfg_q.op == OP_ADD && !cfg_q.partial) begin
                                state_q <= ST_CMP;
                                idx_q   <= LAST_IDX;
                            end else begin
                                state_q <= ST_EMIT;
                                idx_q   <= '0;
                            end
                        end else begin
                            cb_q  <= alu_cout;
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_CMP: begin
                    if (idx_q == '0) begin
                        state_q <= cmp_ge ? ST_FIX : ST_EMIT;
                        cb_q    <= 1'b0;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_FIX: begin
                    if (at_last) begin
                        state_q <= ST_EMIT;
                        idx_q   <= '0;
                        cb_q    <= 1'b0;
                    end else begin
                        cb_q  <= alu_cout;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (at_last) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign out_valid_o = (state_q == ST_EMIT);
    assign out_word_o  = out_valid_o ? st_rdata : '0;
    assign done_o      = out_valid_o && at_last;

endmodule

// File: rtl/modadd_ws_chk.sv
module modadd_ws_chk
    import modadd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       out_valid_o,
    input logic       done_o,
    input mas_state_e st,
    input mas_cfg_t   cfg
);
    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        done_o |-> out_valid_o);                                   // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                       // R7
    AST_STREAM_CONT: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !done_o) |=> out_valid_o);                 // R7
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !out_valid_o);                                 // R10
    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);                          // R10
    AST_FREE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);                                       // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);                           // R9
    AST_CMP_FULL_ADD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMP) |-> (cfg.op == OP_ADD && !cfg.partial));     // R4
endmodule

bind modadd_ws modadd_ws_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .done_o      (done_o),
    .st          (state_q),
    .cfg         (cfg_q)
);

// File: tb/modadd_ws_tb_top.sv
module modadd_ws_tb_top;
    import modadd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W  = DEF_WORD_W;
    localparam int N  = DEF_NUM_WORDS;
    localparam int NW = N * W;
    localparam logic [NW-1:0] P = DEF_MODULUS[NW-1:0];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, sub_i = 1'b0, partial_i = 1'b0, in_valid_i = 1'b0;
    logic [W-1:0] a_word_i = '0, b_word_i = '0;
    logic busy_o, out_valid_o, done_o;
    logic [W-1:0] out_word_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modadd_ws dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sub_i(sub_i),
        .partial_i(partial_i), .in_valid_i(in_valid_i),
        .a_word_i(a_word_i), .b_word_i(b_word_i), .busy_o(busy_o),
        .out_valid_o(out_valid_o), .out_word_o(out_word_o), .done_o(done_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference: result value and number of idle cycles before output.
    task automatic model(input logic [NW-1:0] a, input logic [NW-1:0] b,
                         input bit sub, input bit part,
                         output logic [NW-1:0] res, output int gap);
        logic [NW:0] s;
        if (sub) begin
            s = {1'b0, a} - {1'b0, b};
            if (a < b) begin res = s[NW-1:0] + P; gap = N; end
            else begin res = s[NW-1:0]; gap = 0; end
        end else begin
            s = {1'b0, a} + {1'b0, b};
            if (s[NW]) begin
                res = s[NW-1:0] - P; gap = N;
            end else if (part) begin
                res = s[NW-1:0]; gap = 0;
            end else if (s[NW-1:0] >= P) begin
                res = s[NW-1:0] - P; gap = 2 * N;
            end else begin
                res = s[NW-1:0]; gap = N;
            end
        end
    endtask

    task automatic run_op(input string tag, input logic [NW-1:0] a,
                          input logic [NW-1:0] b, input bit sub, input bit part,
                          input bit gaps);
        logic [NW-1:0] exp;
        int gap;
        model(a, b, sub, part, exp, gap);
        start_i = 1'b1; sub_i = sub; partial_i = part;
        @(negedge clk);
        start_i = 1'b0; sub_i = ~sub; partial_i = ~part;
        for (int i = 0; i < N; i++) begin
            if (gaps && (i % 3 == 1)) begin
                // R8: junk data with valid low; R9: start while busy
                in_valid_i = 1'b0; a_word_i = 16'hDEAD; b_word_i = 16'hBEEF;
                start_i = (i == 1);
                @(negedge clk);
                start_i = 1'b0;
                check({tag, " R8"}, "out_valid during load", {15'd0, out_valid_o}, '0);
            end
            in_valid_i = 1'b1;
            a_word_i = a[i*W +: W]; b_word_i = b[i*W +: W];
            @(negedge clk);
        end
        in_valid_i = 1'b0; a_word_i = '0; b_word_i = '0;
        for (int c = 0; c < gap; c++) begin
            check({tag, " R6"}, "out_valid idle", {15'd0, out_valid_o}, '0);
            check({tag, " R10"}, "busy", {15'd0, busy_o}, 16'd1);
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) begin
            check({tag, " R7"}, "out_valid", {15'd0, out_valid_o}, 16'd1);
            check(tag, $sformatf("word %0d", i), out_word_o, exp[i*W +: W]);
            check({tag, " R7"}, "done", {15'd0, done_o}, {15'd0, (i == N-1)});
            @(negedge clk);
        end
        check({tag, " R10"}, "busy after done", {15'd0, busy_o}, '0);
        check({tag, " R7"}, "out_valid after done", {15'd0, out_valid_o}, '0);
    endtask

    function automatic logic [NW-1:0] rnd_val();
        logic [NW-1:0] v;
        for (int k = 0; k < NW / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [NW-1:0] ra, rb;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "busy", {15'd0, busy_o}, '0);
        check("R1", "out_valid", {15'd0, out_valid_o}, '0);
        check("R1", "done", {15'd0, done_o}, '0);
        run_op("R2 small add", NW'(1), NW'(2), 1'b0, 1'b0, 1'b0);
        run_op("R3 sum equals p", P - 1, NW'(1), 1'b0, 1'b0, 1'b0);
        run_op("R3 carry out", P - 1, P - 1, 1'b0, 1'b0, 1'b0);
        run_op("R2 just below p", P - 5, NW'(3), 1'b0, 1'b0, 1'b0);
        run_op("R4 partial carry", '1, '1, 1'b0, 1'b1, 1'b0);
        run_op("R4 partial above p", P + 3, NW'(1), 1'b0, 1'b1, 1'b0);
        run_op("R5 sub no borrow", NW'(5), NW'(3), 1'b1, 1'b0, 1'b0);
        run_op("R5 sub borrow", NW'(3), NW'(5), 1'b1, 1'b0, 1'b0);
        run_op("R5 sub equal", P - 9, P - 9, 1'b1, 1'b1, 1'b0);
        run_op("R9 gapped", P - 1, NW'(1), 1'b0, 1'b0, 1'b1);
        run_op("R8 gapped sub", NW'(3), NW'(5), 1'b1, 1'b0, 1'b1);
        for (int t = 0; t < 8; t++) begin
            ra = rnd_val(); rb = rnd_val();
            if (t % 4 != 3) begin
                if (ra >= P) ra = ra - P;
                if (rb >= P) rb = rb - P;
            end
            run_op($sformatf("R2 random %0d", t), ra, rb, t[0], (t % 4 == 3), t[1]);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule